// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This peripheral watches over system software with a 64-bit up-counter and a 64-bit period. Each of the two is reached as a pair of 32-bit words through a simple single-cycle register port. Software sets up the period, the count mode and the watchdog mode while the block is idle. It then arms the watchdog by writing two fixed keys into the key field of the watchdog control word. From the first key onward, every configuration word is frozen. Only the key field of the watchdog control word is still accepted.

Once armed, software must keep repeating the same two-key pair. Each completed pair restarts the count at zero. If the count reaches the period, or if software writes a key out of sequence, the block raises a sticky timeout flag. It also drives a reset request for a fixed number of clock cycles. Only a hardware reset of the block returns it to idle.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every mapped word reads zero, the block is idle and `rst_req` is low.
- R2: While idle, writes take effect at the clock edge of the write strobe. The word map is:
  - 0x10 and 0x14: low and high halves of the count.
  - 0x18 and 0x1C: low and high halves of the period.
  - 0x20: control word; only bits [7:6] (count mode) are stored.
  - 0x24: global word; only bits [3:0] are stored.
  - 0x28: watchdog control word. Bit 14 is the enable and reads back as written. Bit 15 is the timeout flag and is read-only. Bits [31:16] always read zero.
  - Any other offset reads zero.
- R3: The block arms only in this way. A write to 0x28 with key 0xA5C6 in [31:16], bit 14 set and global bits [3:2] equal to 2 enters the pre-active state. A later write of key 0xDA7E enters the active state. The key 0xA5C6 without bit 14, or with the mode field not 2, leaves the block idle and unlocked. Any other key written while idle has no effect.
- R4: From pre-active onward, writes to 0x10 through 0x24 are ignored. In writes to 0x28, only the key field is used; bit 14 keeps its value.
- R5: In the active and service states, the count rises by one each cycle, with carry from the low word into the high word. This needs a non-zero count mode and both global bits 0 and 1 set. With count mode 0, the count holds.
- R6: In the active state, key 0xA5C6 enters the service state, and the count keeps running. Then key 0xDA7E returns to active, and the count is zero in the cycle after that write.
- R7: While counting, the timeout flag is set at the clock edge after the cycle in which the count equals the period. The count then holds; a period of zero expires one cycle after arming.
- R8: The flag stays set, and the block ignores all writes, until a hardware reset, which clears everything.
- R9: `rst_req` is high for exactly 16 cycles, starting in the same cycle as the flag.
- R10: A key other than the expected one, written in the pre-active, active or service state, sets the flag and starts `rst_req` at the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Reset request after a timeout |

## Verification
Register writes and key writes show their effect in the first cycle after the write edge, and read data is combinational. Each bench task therefore drives a write across one edge and reads back at the following falling edge.

Counting starts one edge after the arming write. The count equals the period P edges later, and the flag follows one edge after that. The bench counts these edges exactly from the edge of the arming write. It checks that the flag is still clear at count P, set one cycle later, and that `rst_req` is high 15 cycles after that and low one cycle further on.

A bad key sets the flag at the edge of the write itself, so its check samples at the very next falling edge.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACTIVE,
    ST_SVC,
    ST_EXPIRED
  } wdg_state_e;

  localparam logic [15:0] KEY_OPEN  = 16'hA5C6;
  localparam logic [15:0] KEY_CLOSE = 16'hDA7E;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PER_LO = 8'h18;
  localparam logic [7:0] OFS_PER_HI = 8'h1C;
  localparam logic [7:0] OFS_TCTL   = 8'h20;
  localparam logic [7:0] OFS_GCTL   = 8'h24;
  localparam logic [7:0] OFS_WDCTL  = 8'h28;

  localparam logic [1:0] GMODE_WDOG = 2'd2;

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [15:0] key,
  input  logic       en_bit,
  input  logic       wdog_mode,
  input  logic       cmp_hit,
  output wdg_state_e state,
  output logic       arm_evt,
  output logic       restart_evt,
  output logic       fault_evt,
  output logic       locked,
  output logic       armed
);

  wdg_state_e nxt;

  always_comb begin
    nxt         = state;
    arm_evt     = 1'b0;
    restart_evt = 1'b0;
    fault_evt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (key_wr && key == KEY_OPEN && en_bit && wdog_mode) nxt = ST_PRE;
      end
      ST_PRE: begin
        if (key_wr) begin
          if (key == KEY_CLOSE) begin
            nxt     = ST_ACTIVE;
            arm_evt = 1'b1;
          end else begin
            nxt       = ST_EXPIRED;
            fault_evt = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (cmp_hit) nxt = ST_EXPIRED;
        else if (key_wr) begin
          if (key == KEY_OPEN) nxt = ST_SVC;
          else begin
            nxt       = ST_EXPIRED;
            fault_evt = 1'b1;
          end
        end
      end
      ST_SVC: begin
        if (cmp_hit) nxt = ST_EXPIRED;
        else if (key_wr) begin
          if (key == KEY_CLOSE) begin
            nxt         = ST_ACTIVE;
            restart_evt = 1'b1;
          end else begin
            nxt       = ST_EXPIRED;
            fault_evt = 1'b1;
          end
        end
      end
      default: nxt = ST_EXPIRED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign locked = (state != ST_IDLE);
  assign armed  = (state == ST_ACTIVE) || (state == ST_SVC);

endmodule

// File: rtl/kwdt_count64.sv
module kwdt_count64 #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                clear,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [HALF_W-1:0]   ld_data,
  input  logic [2*HALF_W-1:0] limit,
  output logic [2*HALF_W-1:0] value,
  output logic                hit
);

  localparam int FULL_W = 2 * HALF_W;

  function automatic logic [FULL_W-1:0] advance(input logic [FULL_W-1:0] v);
    return v + FULL_W'(1);
  endfunction

  assign hit = run && (value == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          value <= '0;
    else if (clear)      value <= '0;
    else if (ld_lo)      value[HALF_W-1:0] <= ld_data;
    else if (ld_hi)      value[FULL_W-1:HALF_W] <= ld_data;
    else if (run && !hit) value <= advance(value);
  end

endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);

  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (trig)         left <= CW'(HOLD);
    else if (left != '0)   left <= left - CW'(1);
  end

  assign active = (left != '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int REQ_HOLD = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] per_q;
  logic [FULL_W-1:0] cnt_q;
  logic [1:0]        mode_q;
  logic [3:0]        gctl_q;
  logic              en_q;
  logic              flag_q;

  wdg_state_e state;
  logic       arm_evt, restart_evt, fault_evt, locked, armed;
  logic       cmp_hit, run, tmo_evt;

  logic cfg_wr;
  logic wr_cnt_lo, wr_cnt_hi, wr_per_lo, wr_per_hi, wr_tctl, wr_gctl, wr_wd;

  assign cfg_wr    = bus_we && !locked;
  assign wr_cnt_lo = cfg_wr && bus_addr == OFS_CNT_LO;
  assign wr_cnt_hi = cfg_wr && bus_addr == OFS_CNT_HI;
  assign wr_per_lo = cfg_wr && bus_addr == OFS_PER_LO;
  assign wr_per_hi = cfg_wr && bus_addr == OFS_PER_HI;
  assign wr_tctl   = cfg_wr && bus_addr == OFS_TCTL;
  assign wr_gctl   = cfg_wr && bus_addr == OFS_GCTL;
  assign wr_wd     = bus_we && bus_addr == OFS_WDCTL;

  assign run     = armed && (mode_q != 2'd0) && (gctl_q[1:0] == 2'b11);
  assign tmo_evt = cmp_hit || fault_evt;

  kwdt_keyseq u_keyseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (wr_wd),
    .key         (bus_wdata[31:16]),
    .en_bit      (bus_wdata[14]),
    .wdog_mode   (gctl_q[3:2] == GMODE_WDOG),
    .cmp_hit     (cmp_hit),
    .state       (state),
    .arm_evt     (arm_evt),
    .restart_evt (restart_evt),
    .fault_evt   (fault_evt),
    .locked      (locked),
    .armed       (armed)
  );

  kwdt_count64 #(.HALF_W(HALF_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .clear   (restart_evt),
    .ld_lo   (wr_cnt_lo),
    .ld_hi   (wr_cnt_hi),
    .ld_data (bus_wdata[HALF_W-1:0]),
    .limit   (per_q),
    .value   (cnt_q),
    .hit     (cmp_hit)
  );

  kwdt_stretch #(.HOLD(REQ_HOLD)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (tmo_evt),
    .active (rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      mode_q <= '0;
      gctl_q <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_per_lo) per_q[HALF_W-1:0]      <= bus_wdata[HALF_W-1:0];
      if (wr_per_hi) per_q[FULL_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
      if (wr_tctl)   mode_q <= bus_wdata[7:6];
      if (wr_gctl)   gctl_q <= bus_wdata[3:0];
      if (wr_wd && !locked) en_q <= bus_wdata[14];
      if (tmo_evt)   flag_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CNT_LO: bus_rdata = 32'(cnt_q[HALF_W-1:0]);
      OFS_CNT_HI: bus_rdata = 32'(cnt_q[FULL_W-1:HALF_W]);
      OFS_PER_LO: bus_rdata = 32'(per_q[HALF_W-1:0]);
      OFS_PER_HI: bus_rdata = 32'(per_q[FULL_W-1:HALF_W]);
      OFS_TCTL:   bus_rdata = {24'd0, mode_q, 6'd0};
      OFS_GCTL:   bus_rdata = {28'd0, gctl_q};
      OFS_WDCTL:  bus_rdata = {16'd0, flag_q, en_q, 14'd0};
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int FULL_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              run,
  input logic              cmp_hit,
  input logic              fault_evt,
  input logic              restart_evt,
  input logic              flag_q,
  input logic              rst_req,
  input logic [FULL_W-1:0] per_q,
  input logic [FULL_W-1:0] cnt_q
);

  a_r4_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(per_q));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmp_hit && !restart_evt) |=> (cnt_q == $past(cnt_q) + FULL_W'(1)));

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (cnt_q == '0));

  a_r7_hit_expires: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (flag_q && $stable(cnt_q)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);

  a_r9_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> rst_req);

  a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag_q);

  a_r10_fault_expires: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (flag_q && rst_req));

endmodule

bind kwdt_top kwdt_chk #(.FULL_W(FULL_W)) u_kwdt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .locked      (locked),
  .run         (run),
  .cmp_hit     (cmp_hit),
  .fault_evt   (fault_evt),
  .restart_evt (restart_evt),
  .flag_q      (flag_q),
  .rst_req     (rst_req),
  .per_q       (per_q),
  .cnt_q       (cnt_q)
);

// File: tb/test_kwdt_top.sv
module test_kwdt_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;

  kwdt_top i_kwdt_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] plo, input logic [31:0] phi, input logic [31:0] tctl);
    wr(8'h18, plo);
    wr(8'h1C, phi);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h20, tctl);
    wr(8'h24, 32'hB);
  endtask

  task automatic arm();
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h28, 32'hDA7E_4000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 8'h10; a <= 8'h28; a += 4) begin
      rd(8'(a), v); chk("R1 reset word", v, 32'h0);
    end
    chk("R1 reset rst_req", 32'(rst_req), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(8'h18, 32'h1234_5678); rd(8'h18, v); chk("R2 period low", v, 32'h1234_5678);
    wr(8'h1C, 32'h9ABC_DEF0); rd(8'h1C, v); chk("R2 period high", v, 32'h9ABC_DEF0);
    wr(8'h10, 32'h0000_0042); rd(8'h10, v); chk("R2 count low", v, 32'h42);
    wr(8'h14, 32'h0000_0007); rd(8'h14, v); chk("R2 count high", v, 32'h7);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 control mask", v, 32'hC0);
    wr(8'h24, 32'hFFFF_FFF3); rd(8'h24, v); chk("R2 global mask", v, 32'h3);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R2 wd control, flag read-only", v, 32'h4000);
    rd(8'h2C, v); chk("R2 unmapped 0x2C", v, 32'h0);
    rd(8'h00, v); chk("R2 unmapped 0x00", v, 32'h0);
  endtask

  task automatic t_noarm();
    logic [31:0] v;
    do_reset();
    wr(8'h24, 32'hB);
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h18, 32'h7); rd(8'h18, v); chk("R3 key without enable stays idle", v, 32'h7);
    wr(8'h24, 32'h3);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h18, 32'h9); rd(8'h18, v); chk("R3 key without wdog mode stays idle", v, 32'h9);
    wr(8'h28, 32'hDA7E_4000);
    rd(8'h28, v); chk("R3 second key in idle no effect", v, 32'h4000);
    chk("R3 no reset request in idle", 32'(rst_req), 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    setup(32'd100, 32'd0, 32'h80);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h18, 32'h5);   rd(8'h18, v); chk("R4 period locked", v, 32'd100);
    wr(8'h10, 32'h55);  rd(8'h10, v); chk("R4 count locked", v, 32'h0);
    wr(8'h20, 32'h0);   rd(8'h20, v); chk("R4 control locked", v, 32'h80);
    wr(8'h24, 32'h0);   rd(8'h24, v); chk("R4 global locked", v, 32'hB);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h28, v); chk("R4 enable bit kept", v, 32'h4000);
    rd(8'h10, v); chk("R3 count at arm", v, 32'h0);
    cycles(1);
    rd(8'h10, v); chk("R3 count runs after arm", v, 32'h1);
  endtask

  task automatic t_count();
    logic [31:0] v;
    do_reset();
    setup(32'd0, 32'd2, 32'h80);
    wr(8'h10, 32'hFFFF_FFFE);
    arm();
    rd(8'h10, v); chk("R5 start low", v, 32'hFFFF_FFFE);
    cycles(2);
    rd(8'h10, v); chk("R5 carry low", v, 32'h0);
    rd(8'h14, v); chk("R5 carry high", v, 32'h1);
    do_reset();
    setup(32'd3, 32'd0, 32'h0);
    arm();
    cycles(6);
    rd(8'h10, v); chk("R5 mode 0 holds count", v, 32'h0);
    rd(8'h28, v); chk("R5 mode 0 no timeout", v, 32'h4000);
  endtask

  task automatic t_service();
    logic [31:0] v;
    do_reset();
    setup(32'd1000, 32'd0, 32'h80);
    arm();
    cycles(10);
    wr(8'h28, 32'hA5C6_0000);
    rd(8'h10, v); chk("R6 count runs in service", v, 32'd12);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, v); chk("R6 restart at zero", v, 32'h0);
    cycles(3);
    rd(8'h10, v); chk("R6 counts after restart", v, 32'd3);
    rd(8'h28, v); chk("R6 no timeout", v, 32'h4000);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    do_reset();
    setup(32'd5, 32'd0, 32'h40);
    arm();
    cycles(5);
    rd(8'h10, v); chk("R7 count reaches period", v, 32'd5);
    rd(8'h28, v); chk("R7 flag clear at equality", v, 32'h4000);
    cycles(1);
    rd(8'h28, v); chk("R7 flag set next edge", v, 32'hC000);
    rd(8'h10, v); chk("R7 count holds", v, 32'd5);
    chk("R9 request starts with flag", 32'(rst_req), 32'h1);
    cycles(15);
    chk("R9 request still high at 16th cycle", 32'(rst_req), 32'h1);
    cycles(1);
    chk("R9 request low after 16 cycles", 32'(rst_req), 32'h0);
    wr(8'h18, 32'h77); rd(8'h18, v); chk("R8 writes ignored after timeout", v, 32'd5);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h28, v); chk("R8 flag sticky", v, 32'hC000);
    do_reset();
    rd(8'h28, v); chk("R8 reset clears flag", v, 32'h0);
    chk("R8 reset clears request", 32'(rst_req), 32'h0);
    setup(32'd0, 32'd0, 32'h80);
    arm();
    rd(8'h28, v); chk("R7 zero period before edge", v, 32'h4000);
    cycles(1);
    rd(8'h28, v); chk("R7 zero period expires", v, 32'hC000);
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    do_reset();
    setup(32'd1000, 32'd0, 32'h80);
    arm();
    wr(8'h28, 32'h1234_0000);
    rd(8'h28, v); chk("R10 bad key in active", v, 32'hC000);
    chk("R10 request on bad key", 32'(rst_req), 32'h1);
    do_reset();
    setup(32'd1000, 32'd0, 32'h80);
    wr(8'h28, 32'hA5C6_4000);
    wr(8'h28, 32'hA5C6_4000);
    rd(8'h28, v); chk("R10 bad key in pre-active", v, 32'hC000);
    do_reset();
    setup(32'd1000, 32'd0, 32'h80);
    arm();
    wr(8'h28, 32'hA5C6_0000);
    wr(8'h28, 32'hA5C6_0000);
    rd(8'h28, v); chk("R10 bad key in service", v, 32'hC000);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_noarm();
    t_lock();
    t_count();
    t_service();
    t_timeout();
    t_badkey();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule